// File: doc/BRIEF.md
# GPIO pad event interrupt controller

This block watches a bank of general-purpose input pads and turns transitions or levels on them into latched interrupt and wake events. Every pad has its own configuration word that picks the event type (active level, single edge, both edges or off), can invert the received signal before detection, can switch off the input receiver, and holds the pad's output value and output-driver disable. Pads are split into fixed-size groups. Each group has an interrupt status word and an interrupt enable word, plus a wake status word and a wake enable word.

Status bits latch detected events and are cleared by writing ones. The interrupt output is raised while any latched and enabled interrupt status bit is set. The wake output works the same way from the wake words, except that a pad whose system-control routing bit is set never contributes to wake. Software reaches all words through a word-addressed port with a one-cycle write and a combinational read.

Pad inputs are resynchronised through two flops. Detection then compares the synchronised value with its value one clock earlier.

Top module: `gpev_ctrl`

## Requirements
- R1: After reset every pad configuration word reads 0x0400_0100 (event type off, output driver disabled). All status and enable words read zero. `irq`, `wake` and every `pad_oe` bit are low.
- R2: The configuration word keeps the event type in bits 26:25, invert in bit 23, routing enables in bits 20:17 (bit 19 is system-control routing), receiver disable in bit 9, driver disable in bit 8 and output value in bit 0. All other bits read zero. Bit 1 is read-only and shows the synchronised pad input, or zero while the receiver is disabled.
- R3: `pad_out[p]` equals bit 0 of pad p's configuration word, and `pad_oe[p]` is the inverse of bit 8.
- R4: Event type 1 latches a rising edge of the received input. With invert set it latches a falling edge instead.
- R5: Event type 3 latches every rising and every falling edge.
- R6: Event type 0 sets the status bit on every clock while the received input, after inversion, is high. With invert set it therefore reacts to a low input.
- R7: Event type 2 never sets a status bit, whatever the pad input does.
- R8: Writing a one to a status bit clears it, and writing a zero leaves it unchanged. When a new event and a clear hit the same bit in the same cycle, the bit stays set.
- R9: `irq` is high exactly when some interrupt status bit and its enable bit are both set. Enable bits do not stop a status bit from latching.
- R10: Bits of the last group that lie beyond the last real pad read zero in every status and enable word and cannot be written.
- R11: Wake status latches the same events as interrupt status. `wake` is high exactly when some pad has its wake status and wake enable set and its bit 19 clear.
- R12: An input change becomes visible in the status word on the third rising clock edge after the change, and not on the second.
- R13: Word addresses are g for interrupt status, 8+g for interrupt enable, 16+g for wake status, 24+g for wake enable (group g), and 32+p for the configuration of pad p. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word (combinational) |
| pad_in | input | NUM_PADS | Raw pad inputs |
| pad_out | output | NUM_PADS | Pad output values |
| pad_oe | output | NUM_PADS | Pad output-driver enables |
| irq | output | 1 | Combined interrupt |
| wake | output | 1 | Combined wake request |

## Verification
A wrong synchroniser depth or a wrong previous-value register makes status bits appear one edge too early or too late. It can also make them appear on the wrong transition, which shows in the status word read on the third edge after a pad change. A bad clear or enable mask shows at `irq` and `wake` in the cycle after the register write, and it also shows as nonzero padding bits when the last group is read. Decoding errors in the event type or invert bit show within three clocks as missing or extra latched bits. The randomised mixes of type, polarity and input patterns expose these.

// File: rtl/gpev_pkg.sv
`timescale 1ns/1ps
package gpev_pkg;
  localparam int REG_W     = 32;
  // word-address map; each group region holds up to GRP_SLOTS groups
  localparam int GRP_SLOTS = 8;
  localparam int STS_BASE  = 0;
  localparam int EN_BASE   = 8;
  localparam int WSTS_BASE = 16;
  localparam int WEN_BASE  = 24;
  localparam int CFG_BASE  = 32;

  localparam logic [1:0] EVM_LEVEL = 2'd0;
  localparam logic [1:0] EVM_EDGE  = 2'd1;
  localparam logic [1:0] EVM_OFF   = 2'd2;
  localparam logic [1:0] EVM_BOTH  = 2'd3;

  // route[3]=bit20, route[2]=bit19 (system control), route[1]=bit18, route[0]=bit17
  typedef struct packed {
    logic [1:0] evmode;
    logic       invert;
    logic [3:0] route;
    logic       rx_off;
    logic       tx_off;
    logic       tx_val;
  } pad_cfg_t;

  localparam pad_cfg_t CFG_RESET = '{evmode: EVM_OFF, invert: 1'b0, route: 4'h0,
                                     rx_off: 1'b0, tx_off: 1'b1, tx_val: 1'b0};

  function automatic logic [REG_W-1:0] cfg_to_word(pad_cfg_t c, logic rx);
    logic [REG_W-1:0] w;
    w        = '0;
    w[26:25] = c.evmode;
    w[23]    = c.invert;
    w[20:17] = c.route;
    w[9]     = c.rx_off;
    w[8]     = c.tx_off;
    w[1]     = rx;
    w[0]     = c.tx_val;
    return w;
  endfunction

  function automatic pad_cfg_t word_to_cfg(logic [REG_W-1:0] w);
    pad_cfg_t c;
    c.evmode = w[26:25];
    c.invert = w[23];
    c.route  = w[20:17];
    c.rx_off = w[9];
    c.tx_off = w[8];
    c.tx_val = w[0];
    return c;
  endfunction

  // cur/prev are already qualified (receiver gate and inversion applied)
  function automatic logic pad_event(logic [1:0] mode, logic cur, logic prev);
    case (mode)
      EVM_LEVEL: return cur;
      EVM_EDGE:  return cur & ~prev;
      EVM_BOTH:  return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] group_valid_mask(int grp, int gsize, int npads);
    logic [REG_W-1:0] m;
    for (int b = 0; b < REG_W; b++)
      m[b] = (b < gsize) && ((grp * gsize + b) < npads);
    return m;
  endfunction
endpackage

// File: rtl/gpev_input_sync.sv
`timescale 1ns/1ps
module gpev_input_sync #(
  parameter int NUM_PADS = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] rx_now,
  output logic [NUM_PADS-1:0] rx_last
);
  logic [NUM_PADS-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= '0;
      rx_now  <= '0;
      rx_last <= '0;
    end else begin
      meta_q  <= pad_in;
      rx_now  <= meta_q;
      rx_last <= rx_now;
    end
  end
endmodule

// File: rtl/gpev_pad_cfg.sv
`timescale 1ns/1ps
module gpev_pad_cfg
  import gpev_pkg::*;
#(
  parameter int NUM_PADS = 20,
  parameter int ADDR_W   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [REG_W-1:0]           wr_data,
  output pad_cfg_t [NUM_PADS-1:0]    cfg_o
);
  pad_cfg_t cfg_q [NUM_PADS];
  pad_cfg_t cfg_new;

  assign cfg_new = word_to_cfg(wr_data);

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CFG_BASE + p);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[p] <= CFG_RESET;
      else if (wr_en && (wr_addr == MY_ADDR))
        cfg_q[p] <= cfg_new;
    end
    assign cfg_o[p] = cfg_q[p];
  end
endmodule

// File: rtl/gpev_group_bank.sv
`timescale 1ns/1ps
module gpev_group_bank
  import gpev_pkg::*;
#(
  parameter int NUM_PADS   = 20,
  parameter int GROUP_SIZE = 8,
  parameter int ADDR_W     = 6,
  parameter int STS_ADDR   = 0,
  parameter int EN_ADDR    = 8,
  localparam int NUM_GROUPS = (NUM_PADS + GROUP_SIZE - 1) / GROUP_SIZE,
  localparam int PADDED     = NUM_GROUPS * GROUP_SIZE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [GROUP_SIZE-1:0] wr_data,
  input  logic [PADDED-1:0]     set_vec,
  output logic [PADDED-1:0]     sts_o,
  output logic [PADDED-1:0]     en_o,
  output logic [PADDED-1:0]     clr_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam logic [REG_W-1:0]      VM32  = group_valid_mask(g, GROUP_SIZE, NUM_PADS);
    localparam logic [GROUP_SIZE-1:0] VMASK = VM32[GROUP_SIZE-1:0];
    localparam logic [ADDR_W-1:0]     A_STS = ADDR_W'(STS_ADDR + g);
    localparam logic [ADDR_W-1:0]     A_EN  = ADDR_W'(EN_ADDR + g);

    logic [GROUP_SIZE-1:0] sts_q, en_q, clr_g, set_g;

    assign clr_g = (wr_en && (wr_addr == A_STS)) ? (wr_data & VMASK) : '0;
    assign set_g = set_vec[g*GROUP_SIZE +: GROUP_SIZE] & VMASK;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sts_q <= '0;
        en_q  <= '0;
      end else begin
        // a new event in the same cycle beats the clear
        sts_q <= (sts_q & ~clr_g) | set_g;
        if (wr_en && (wr_addr == A_EN))
          en_q <= wr_data & VMASK;
      end
    end

    assign sts_o[g*GROUP_SIZE +: GROUP_SIZE] = sts_q;
    assign en_o [g*GROUP_SIZE +: GROUP_SIZE] = en_q;
    assign clr_o[g*GROUP_SIZE +: GROUP_SIZE] = clr_g;
  end
endmodule

// File: rtl/gpev_ctrl.sv
`timescale 1ns/1ps
module gpev_ctrl
  import gpev_pkg::*;
#(
  parameter int NUM_PADS   = 20,
  parameter int GROUP_SIZE = 8,
  parameter int ADDR_W     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic                irq,
  output logic                wake
);
  localparam int NUM_GROUPS = (NUM_PADS + GROUP_SIZE - 1) / GROUP_SIZE;
  localparam int PADDED     = NUM_GROUPS * GROUP_SIZE;

  pad_cfg_t [NUM_PADS-1:0] cfg_arr;
  logic [NUM_PADS-1:0] rx_now, rx_last, rx_live;
  logic [NUM_PADS-1:0] evt_pad, pad_evoff, pad_sci_route;
  logic [PADDED-1:0]   evt_vec, wake_ok;
  logic [PADDED-1:0]   sts_vec, en_vec, sts_clr;
  logic [PADDED-1:0]   wsts_vec, wen_vec, wsts_clr;

  gpev_input_sync #(.NUM_PADS(NUM_PADS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .rx_now(rx_now), .rx_last(rx_last)
  );

  gpev_pad_cfg #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .cfg_o(cfg_arr)
  );

  // per-pad receive qualification and event detection
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_evt
    logic q_cur, q_prev;
    assign rx_live[p]       = rx_now[p] & ~cfg_arr[p].rx_off;
    assign q_cur            = rx_live[p] ^ cfg_arr[p].invert;
    assign q_prev           = (rx_last[p] & ~cfg_arr[p].rx_off) ^ cfg_arr[p].invert;
    assign evt_pad[p]       = pad_event(cfg_arr[p].evmode, q_cur, q_prev);
    assign pad_evoff[p]     = (cfg_arr[p].evmode == EVM_OFF);
    assign pad_sci_route[p] = cfg_arr[p].route[2];
    assign pad_out[p]       = cfg_arr[p].tx_val;
    assign pad_oe[p]        = ~cfg_arr[p].tx_off;
  end

  always_comb begin
    evt_vec = '0;
    wake_ok = '0;
    evt_vec[NUM_PADS-1:0] = evt_pad;
    wake_ok[NUM_PADS-1:0] = ~pad_sci_route;
  end

  gpev_group_bank #(
    .NUM_PADS(NUM_PADS), .GROUP_SIZE(GROUP_SIZE), .ADDR_W(ADDR_W),
    .STS_ADDR(STS_BASE), .EN_ADDR(EN_BASE)
  ) u_irq_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata[GROUP_SIZE-1:0]), .set_vec(evt_vec),
    .sts_o(sts_vec), .en_o(en_vec), .clr_o(sts_clr)
  );

  gpev_group_bank #(
    .NUM_PADS(NUM_PADS), .GROUP_SIZE(GROUP_SIZE), .ADDR_W(ADDR_W),
    .STS_ADDR(WSTS_BASE), .EN_ADDR(WEN_BASE)
  ) u_wake_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata[GROUP_SIZE-1:0]), .set_vec(evt_vec),
    .sts_o(wsts_vec), .en_o(wen_vec), .clr_o(wsts_clr)
  );

  assign irq  = |(sts_vec & en_vec);
  assign wake = |(wsts_vec & wen_vec & wake_ok);

  // read mux
  always_comb begin
    reg_rdata = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (reg_addr == ADDR_W'(STS_BASE + g))  reg_rdata[GROUP_SIZE-1:0] = sts_vec [g*GROUP_SIZE +: GROUP_SIZE];
      if (reg_addr == ADDR_W'(EN_BASE + g))   reg_rdata[GROUP_SIZE-1:0] = en_vec  [g*GROUP_SIZE +: GROUP_SIZE];
      if (reg_addr == ADDR_W'(WSTS_BASE + g)) reg_rdata[GROUP_SIZE-1:0] = wsts_vec[g*GROUP_SIZE +: GROUP_SIZE];
      if (reg_addr == ADDR_W'(WEN_BASE + g))  reg_rdata[GROUP_SIZE-1:0] = wen_vec [g*GROUP_SIZE +: GROUP_SIZE];
    end
    for (int p = 0; p < NUM_PADS; p++) begin
      if (reg_addr == ADDR_W'(CFG_BASE + p)) reg_rdata = cfg_to_word(cfg_arr[p], rx_live[p]);
    end
  end
endmodule

// File: rtl/gpev_ctrl_chk.sv
`timescale 1ns/1ps
module gpev_ctrl_chk #(
  parameter int NUM_PADS   = 20,
  parameter int GROUP_SIZE = 8,
  localparam int NUM_GROUPS = (NUM_PADS + GROUP_SIZE - 1) / GROUP_SIZE,
  localparam int PADDED     = NUM_GROUPS * GROUP_SIZE
) (
  input logic                clk,
  input logic                rst_n,
  input logic                irq,
  input logic                wake,
  input logic [PADDED-1:0]   evt_vec,
  input logic [PADDED-1:0]   sts_vec,
  input logic [PADDED-1:0]   en_vec,
  input logic [PADDED-1:0]   sts_clr,
  input logic [PADDED-1:0]   wsts_vec,
  input logic [PADDED-1:0]   wen_vec,
  input logic [PADDED-1:0]   wsts_clr,
  input logic [NUM_PADS-1:0] pad_evoff,
  input logic [NUM_PADS-1:0] pad_sci_route
);
  logic [PADDED-1:0] real_bits;
  logic [PADDED-1:0] wake_ready;
  logic              wake_unrouted;

  for (genvar b = 0; b < PADDED; b++) begin : g_real
    assign real_bits[b] = (b < NUM_PADS);
  end
  assign wake_ready    = wsts_vec & wen_vec;
  assign wake_unrouted = |(wake_ready[NUM_PADS-1:0] & ~pad_sci_route);

  // R10: padding bits stay clear
  p_padding_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_vec | en_vec | wsts_vec | wen_vec) & ~real_bits) == '0);

  // R4: a detected event is latched on the next edge
  p_event_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_vec) |=> ((sts_vec & $past(evt_vec)) == $past(evt_vec)));

  // R8: a written one clears the bit unless a new event hit it
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|sts_clr) |=> ((sts_vec & $past(sts_clr & ~evt_vec)) == '0));

  // R11: wake status clears the same way
  p_wclear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|wsts_clr) |=> ((wsts_vec & $past(wsts_clr & ~evt_vec)) == '0));

  // R7: pads with the off type produce no event
  p_off_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec[NUM_PADS-1:0] & pad_evoff) == '0);

  // R9: the interrupt needs a latched and an enabled bit
  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|sts_vec) && (|en_vec)));

  // R11: wake only from an enabled pad without system-control routing
  p_wake_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> wake_unrouted);
endmodule

bind gpev_ctrl gpev_ctrl_chk #(.NUM_PADS(NUM_PADS), .GROUP_SIZE(GROUP_SIZE)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .wake(wake), .evt_vec(evt_vec),
  .sts_vec(sts_vec), .en_vec(en_vec), .sts_clr(sts_clr),
  .wsts_vec(wsts_vec), .wen_vec(wen_vec), .wsts_clr(wsts_clr),
  .pad_evoff(pad_evoff), .pad_sci_route(pad_sci_route)
);

// File: tb/gpev_ctrl_tb.sv
`timescale 1ns/1ps
module gpev_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 20;
  localparam int GS = 8;
  localparam int AW = 6;
  localparam int NG = (NP + GS - 1) / GS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic          irq, wake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpev_ctrl #(.NUM_PADS(NP), .GROUP_SIZE(GS), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq), .wake(wake)
  );

  // address map from R13
  function automatic int a_sts(int g);  return g;      endfunction
  function automatic int a_en(int g);   return 8 + g;  endfunction
  function automatic int a_wsts(int g); return 16 + g; endfunction
  function automatic int a_wen(int g);  return 24 + g; endfunction
  function automatic int a_cfg(int p);  return 32 + p; endfunction

  function automatic logic [31:0] cfg_word(logic [1:0] m, logic inv);
    return 32'h0000_0100 | (32'(m) << 25) | (32'(inv) << 23);
  endfunction

  function automatic logic exp_event(logic [1:0] m, logic inv, logic a, logic b);
    logic qa, qb;
    qa = a ^ inv;
    qb = b ^ inv;
    case (m)
      2'd0: return qb;
      2'd1: return qb & ~qa;
      2'd3: return qa ^ qb;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] grp_mask(int g);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < GS; b++) m[b] = (g * GS + b) < NP;
    return m;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(string req, int a, logic [31:0] exp);
    reg_addr = AW'(a);
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      report();
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h1A2B);
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd_check("R1 cfg pad0", a_cfg(0), 32'h0400_0100);
    rd_check("R1 cfg last pad", a_cfg(NP-1), 32'h0400_0100);
    rd_check("R1 status g0", a_sts(0), 32'h0);
    rd_check("R1 wake enable g2", a_wen(2), 32'h0);
    check("R1 irq/wake", {30'b0, irq, wake}, 32'h0);
    check("R1 pad_oe", 32'(pad_oe), 32'h0);

    // R3 output value and driver enable
    wr(a_cfg(3), 32'h0400_0001);
    check("R3 pad_out", 32'(pad_out), 32'h8);
    check("R3 pad_oe", 32'(pad_oe), 32'h8);

    // R2 receive state bit, read-only, gated by receiver disable
    pad_in[3] = 1'b1; idle(3);
    rd_check("R2 rx state", a_cfg(3), 32'h0400_0003);
    pad_in[3] = 1'b0; idle(3);
    wr(a_cfg(3), 32'h0400_0003);
    rd_check("R2 bit1 read-only", a_cfg(3), 32'h0400_0001);
    pad_in[3] = 1'b1; idle(3);
    wr(a_cfg(3), 32'hFFFF_FFFF);
    rd_check("R2 writable bits, rx gated", a_cfg(3), 32'h069E_0301);
    wr(a_cfg(3), 32'h0400_0100);
    pad_in[3] = 1'b0;

    // R4 and R12 rising edge with latency, R9 interrupt
    wr(a_en(0), 32'h20);
    wr(a_cfg(5), 32'h0200_0100);
    idle(2);
    pad_in[5] = 1'b1;
    idle(2);
    rd_check("R12 not after two edges", a_sts(0), 32'h0);
    idle(1);
    rd_check("R12 R4 set on third edge", a_sts(0), 32'h20);
    check("R9 irq high", 32'(irq), 32'h1);
    wr(a_sts(0), 32'h0);
    rd_check("R8 zero write no effect", a_sts(0), 32'h20);
    wr(a_sts(0), 32'h20);
    rd_check("R8 one write clears", a_sts(0), 32'h0);
    check("R9 irq low after clear", 32'(irq), 32'h0);
    pad_in[5] = 1'b0; idle(4);
    rd_check("R4 falling ignored", a_sts(0), 32'h0);
    wr(a_cfg(5), 32'h0280_0100);
    pad_in[5] = 1'b1; idle(4);
    rd_check("R4 inverted rising ignored", a_sts(0), 32'h0);
    pad_in[5] = 1'b0; idle(4);
    rd_check("R4 inverted falling latched", a_sts(0), 32'h20);
    wr(a_sts(0), 32'hFF);
    wr(a_en(0), 32'h0);

    // R5 both edges
    wr(a_cfg(6), 32'h0600_0100);
    pad_in[6] = 1'b1; idle(4);
    rd_check("R5 rise", a_sts(0), 32'h40);
    wr(a_sts(0), 32'h40);
    pad_in[6] = 1'b0; idle(4);
    rd_check("R5 fall", a_sts(0), 32'h40);
    wr(a_sts(0), 32'h40);

    // R6 level mode, R8 set wins over clear
    wr(a_cfg(7), 32'h0000_0100);
    idle(3);
    rd_check("R6 low level idle", a_sts(0), 32'h0);
    pad_in[7] = 1'b1; idle(4);
    rd_check("R6 high level", a_sts(0), 32'h80);
    wr(a_sts(0), 32'h80);
    rd_check("R8 set wins while level active", a_sts(0), 32'h80);
    pad_in[7] = 1'b0; idle(3);
    wr(a_sts(0), 32'h80);
    rd_check("R6 clear after level gone", a_sts(0), 32'h0);
    wr(a_cfg(7), 32'h0080_0100);
    idle(2);
    rd_check("R6 active-low level", a_sts(0), 32'h80);
    wr(a_cfg(7), 32'h0400_0100);
    wr(a_sts(0), 32'h80);
    rd_check("R6 cleared after off", a_sts(0), 32'h0);

    // R7 off type
    pad_in[8] = 1'b1; idle(4);
    rd_check("R7 off no status", a_sts(1), 32'h0);
    rd_check("R7 off no wake status", a_wsts(1), 32'h0);

    // R11 wake path
    wr(a_wen(1), 32'h02);
    wr(a_cfg(9), 32'h0200_0100);
    pad_in[9] = 1'b1; idle(4);
    rd_check("R11 wake status", a_wsts(1), 32'h02);
    check("R11 wake high", 32'(wake), 32'h1);
    check("R9 irq held off by enable", 32'(irq), 32'h0);
    rd_check("R9 status latched without enable", a_sts(1), 32'h02);
    wr(a_cfg(9), 32'h0208_0100);
    check("R11 system-control routing blocks wake", 32'(wake), 32'h0);
    rd_check("R11 wake status kept", a_wsts(1), 32'h02);
    wr(a_cfg(9), 32'h0200_0100);
    check("R11 wake back", 32'(wake), 32'h1);
    wr(a_wsts(1), 32'h02);
    check("R11 wake cleared", 32'(wake), 32'h0);
    wr(a_wen(1), 32'h0);
    wr(a_sts(1), 32'hFF);

    // R10 partial last group
    wr(a_en(2), 32'hFFFF_FFFF);
    rd_check("R10 last group enable", a_en(2), 32'h0F);
    wr(a_en(0), 32'hFFFF_FFFF);
    rd_check("R10 full group enable", a_en(0), 32'hFF);
    wr(a_wen(2), 32'hFFFF_FFFF);
    rd_check("R10 last group wake enable", a_wen(2), 32'h0F);
    wr(a_en(0), 32'h0); wr(a_en(2), 32'h0); wr(a_wen(2), 32'h0);

    // R13 unmapped addresses
    rd_check("R13 unused group slot", 5, 32'h0);
    rd_check("R13 beyond last pad", 63, 32'h0);

    // random mixes of type, polarity and input pattern (R4 R5 R9)
    for (int it = 0; it < 10; it++) begin
      logic [1:0]    m   [NP];
      logic          inv [NP];
      logic [NP-1:0] pa, pb;
      logic [31:0]   en  [NG];
      logic [NG*GS-1:0] exp_sts;
      logic          exp_irq;
      for (int p = 0; p < NP; p++) begin
        int unsigned r;
        r = $urandom % 3;
        m[p]   = (r == 0) ? 2'd1 : (r == 1) ? 2'd3 : 2'd2;
        inv[p] = 1'($urandom % 2);
        wr(a_cfg(p), cfg_word(m[p], inv[p]));
      end
      for (int g = 0; g < NG; g++) begin
        en[g] = $urandom & grp_mask(g);
        wr(a_en(g), en[g]);
      end
      pa = NP'($urandom);
      pb = NP'($urandom);
      pad_in = pa; idle(4);
      for (int g = 0; g < NG; g++) begin
        wr(a_sts(g), 32'hFF);
        wr(a_wsts(g), 32'hFF);
      end
      pad_in = pb; idle(4);
      exp_sts = '0;
      for (int p = 0; p < NP; p++) exp_sts[p] = exp_event(m[p], inv[p], pa[p], pb[p]);
      exp_irq = 1'b0;
      for (int g = 0; g < NG; g++) begin
        rd_check("R5 random status", a_sts(g), 32'(exp_sts[g*GS +: GS]));
        exp_irq = exp_irq | (|(exp_sts[g*GS +: GS] & en[g][GS-1:0]));
      end
      check("R9 random irq", 32'(irq), 32'(exp_irq));
    end

    done = 1'b1;
    report();
  end
endmodule